// File: doc/BRIEF.md
# Local/System Bus Bridge with Inbound Priority

This block joins a processor's local load/store bus to a shared system bus. Local requests aimed at the on-block data RAM are served there in the same cycle. Local requests that land neither in that RAM nor in a programmable window of memory-mapped local resources go out to the system bus, one at a time. Masters on the system bus can reach the same RAM through an inbound port. When an inbound access and a local access meet in one cycle, the inbound access goes first.

The window of local resources produces one module select per sub-block. The block can send show cycles that copy local RAM accesses onto a trace port. It also has a lock bit that, once set, shuts the system side out of the RAM until reset.

All three data interfaces use valid/ready. A requester raises valid and must keep its address, direction and write data fixed until it sees ready in a cycle. The completed beat is the cycle in which both valid and ready are high, and read data is valid in that cycle. The bridge holds its outbound fields fixed while the system slave withholds ready. An inbound requester that receives retry may keep valid high or drop it.

Top module: `lsb_bridge`

## Requirements
- R1: If an inbound access is accepted in a cycle, a local RAM access pending in that same cycle is not acknowledged. Once inbound accepts are no longer back-to-back, the local access is acknowledged in the following cycle.
- R2: A local request forwards to the system bus if its address is at or above 2**RAM_AW and also outside the select window. Its fields appear on `sout_*` with `sout_valid` in the cycle after the request is taken. The local side is acknowledged in the cycle `sout_ready` is high, and `lreq_rdata` equals `sout_rdata` in that cycle.
- R3: After an outbound beat completes, `sout_valid` is low for exactly one cycle when another forwarded request is already waiting. While `sout_ready` is low, `sout_valid` and the outbound fields stay unchanged.
- R4: Suppose an inbound access was accepted in the previous cycle. An inbound request in the current cycle then gets `sin_retry` high and `sin_ready` low. The inbound access in the cycle after that is accepted.
- R5: The select window covers NSEL sub-blocks of 2**SEL_AW words, starting at `win_base`. While `lreq_valid` is high and the address is in sub-block k, only `mod_sel[k]` is high. An address below 2**RAM_AW is a RAM access and raises no select. In-window requests are neither acknowledged nor forwarded.
- R6: A pulse on `prot_set` raises `prot_lock` in the next cycle. The lock stays high until reset.
- R7: While `prot_lock` is high, an accepted inbound access completes with `sin_ready` and `sin_err` both high. The RAM is not written, and `sin_rdata` is zero.
- R8: The show code on `show_mode` selects when show cycles are sent: 0 or 3 never, 1 for every local RAM access, 2 for local RAM writes only. A show cycle appears one cycle after the local RAM access completes. It carries `show_valid`, the address, the direction, and the write data or the read data.
- R9: Local RAM word addresses are 0 to 2**RAM_AW-1, and the inbound `sin_addr` indexes the same words. Reads return data combinationally, and a write is visible from the next cycle onward.
- R10: In reset and immediately after reset, all handshake outputs, `mod_sel`, `show_valid` and `prot_lock` are low, and every RAM word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request valid |
| lreq_ready | output | 1 | Local request completed |
| lreq_addr | input | AW | Local word address |
| lreq_we | input | 1 | Local write (1) or read (0) |
| lreq_wdata | input | DW | Local write data |
| lreq_rdata | output | DW | Local read data, valid with ready |
| sin_valid | input | 1 | Inbound system request valid |
| sin_ready | output | 1 | Inbound request completed |
| sin_retry | output | 1 | Inbound request refused, try again |
| sin_err | output | 1 | Inbound completion is an error (locked) |
| sin_addr | input | RAM_AW | Inbound RAM word index |
| sin_we | input | 1 | Inbound write (1) or read (0) |
| sin_wdata | input | DW | Inbound write data |
| sin_rdata | output | DW | Inbound read data |
| sout_valid | output | 1 | Outbound system request valid |
| sout_ready | input | 1 | Outbound request completed by the slave |
| sout_addr | output | AW | Outbound word address |
| sout_we | output | 1 | Outbound write (1) or read (0) |
| sout_wdata | output | DW | Outbound write data |
| sout_rdata | input | DW | Outbound read data |
| win_base | input | AW | Base word address of the select window |
| mod_sel | output | NSEL | One-hot select of local resources |
| show_mode | input | 2 | Show cycle code |
| show_valid | output | 1 | Show cycle present |
| show_addr | output | AW | Show cycle address |
| show_we | output | 1 | Show cycle direction |
| show_data | output | DW | Show cycle data |
| prot_set | input | 1 | Set the RAM protection lock |
| prot_lock | output | 1 | RAM protection lock state |

## Verification
The hardest case to reach is a local RAM access that lands in the same cycle as an inbound accept, immediately followed by a second inbound access that should be retried. The stimulus forks a local requester and an inbound requester that start on the same edge, and then issues inbound accesses back to back. A random phase adds a system slave that stalls at random, so forwarded requests overlap inbound traffic and gap cycles. The behavioural model checks every output on every clock, so each of these overlaps is checked wherever it happens to arise.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [1:0] {
    OB_IDLE = 2'd0,
    OB_BUSY = 2'd1,
    OB_GAP  = 2'd2
  } ob_state_e;

  localparam logic [1:0] SHOW_NONE = 2'd0;
  localparam logic [1:0] SHOW_ALL  = 2'd1;
  localparam logic [1:0] SHOW_WR   = 2'd2;
endpackage

// File: rtl/lsb_decode.sv
module lsb_decode #(
  parameter int AW     = 16,
  parameter int RAM_AW = 6,
  parameter int NSEL   = 4,
  parameter int SEL_AW = 4
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   win_base,
  output logic            hit_ram,
  output logic            in_win,
  output logic [NSEL-1:0] mod_sel
);
  localparam logic [AW:0] WIN_SPAN = (AW+1)'(NSEL) << SEL_AW;

  logic [AW-1:0] offset;

  assign hit_ram = (addr[AW-1:RAM_AW] == '0);
  assign offset  = addr - win_base;
  assign in_win  = !hit_ram && ({1'b0, offset} < WIN_SPAN);

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign mod_sel[k] = valid && in_win && ((offset >> SEL_AW) == AW'(k));
  end
endmodule

// File: rtl/lsb_inbound.sv
module lsb_inbound (
  input  logic clk,
  input  logic rst_n,
  input  logic sin_valid,
  input  logic prot_set,
  output logic in_go,
  output logic sin_ready,
  output logic sin_retry,
  output logic sin_err,
  output logic prot_lock
);
  logic prev_q;
  logic lock_q;

  assign in_go     = sin_valid && !prev_q;
  assign sin_ready = in_go;
  assign sin_retry = sin_valid && prev_q;
  assign sin_err   = in_go && lock_q;
  assign prot_lock = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      prev_q <= in_go;
      lock_q <= lock_q || prot_set;
    end
  end
endmodule

// File: rtl/lsb_outbound.sv
module lsb_outbound import lsb_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic [DW-1:0] l_wdata,
  input  logic          sout_ready,
  output logic          sout_valid,
  output logic [AW-1:0] sout_addr,
  output logic          sout_we,
  output logic [DW-1:0] sout_wdata,
  output logic          busy,
  output logic          done
);
  ob_state_e state_q;

  assign busy       = (state_q == OB_BUSY);
  assign sout_valid = busy;
  assign done       = busy && sout_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= OB_IDLE;
      sout_addr  <= '0;
      sout_we    <= 1'b0;
      sout_wdata <= '0;
    end else begin
      case (state_q)
        OB_BUSY: if (sout_ready) state_q <= OB_GAP;
        default: begin
          if (launch) begin
            state_q    <= OB_BUSY;
            sout_addr  <= l_addr;
            sout_we    <= l_we;
            sout_wdata <= l_wdata;
          end else begin
            state_q <= OB_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lsb_ram.sv
module lsb_ram #(
  parameter int RAM_AW = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int WORDS = 1 << RAM_AW;

  logic [DW-1:0] mem [WORDS];

  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/lsb_bridge.sv
module lsb_bridge import lsb_pkg::*; #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int RAM_AW = 6,
  parameter int NSEL   = 4,
  parameter int SEL_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  output logic              lreq_ready,
  input  logic [AW-1:0]     lreq_addr,
  input  logic              lreq_we,
  input  logic [DW-1:0]     lreq_wdata,
  output logic [DW-1:0]     lreq_rdata,
  input  logic              sin_valid,
  output logic              sin_ready,
  output logic              sin_retry,
  output logic              sin_err,
  input  logic [RAM_AW-1:0] sin_addr,
  input  logic              sin_we,
  input  logic [DW-1:0]     sin_wdata,
  output logic [DW-1:0]     sin_rdata,
  output logic              sout_valid,
  input  logic              sout_ready,
  output logic [AW-1:0]     sout_addr,
  output logic              sout_we,
  output logic [DW-1:0]     sout_wdata,
  input  logic [DW-1:0]     sout_rdata,
  input  logic [AW-1:0]     win_base,
  output logic [NSEL-1:0]   mod_sel,
  input  logic [1:0]        show_mode,
  output logic              show_valid,
  output logic [AW-1:0]     show_addr,
  output logic              show_we,
  output logic [DW-1:0]     show_data,
  input  logic              prot_set,
  output logic              prot_lock
);
  logic              hit_ram, in_win, in_go;
  logic              l_ram_ok, launch, ob_busy, ob_done;
  logic              ram_we, show_take;
  logic [RAM_AW-1:0] ram_addr;
  logic [DW-1:0]     ram_wdata, ram_rdata;

  lsb_decode #(.AW(AW), .RAM_AW(RAM_AW), .NSEL(NSEL), .SEL_AW(SEL_AW)) u_dec (
    .valid(lreq_valid), .addr(lreq_addr), .win_base(win_base),
    .hit_ram(hit_ram), .in_win(in_win), .mod_sel(mod_sel)
  );

  lsb_inbound u_in (
    .clk(clk), .rst_n(rst_n), .sin_valid(sin_valid), .prot_set(prot_set),
    .in_go(in_go), .sin_ready(sin_ready), .sin_retry(sin_retry),
    .sin_err(sin_err), .prot_lock(prot_lock)
  );

  // inbound accept wins the RAM and blocks any local start this cycle
  assign l_ram_ok = lreq_valid && hit_ram && !in_go && !ob_busy;
  assign launch   = lreq_valid && !hit_ram && !in_win && !in_go && !ob_busy;

  lsb_outbound #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .l_addr(lreq_addr), .l_we(lreq_we), .l_wdata(lreq_wdata),
    .sout_ready(sout_ready), .sout_valid(sout_valid), .sout_addr(sout_addr),
    .sout_we(sout_we), .sout_wdata(sout_wdata), .busy(ob_busy), .done(ob_done)
  );

  assign ram_addr  = in_go ? sin_addr : lreq_addr[RAM_AW-1:0];
  assign ram_we    = in_go ? (sin_we && !prot_lock) : (l_ram_ok && lreq_we);
  assign ram_wdata = in_go ? sin_wdata : lreq_wdata;

  lsb_ram #(.RAM_AW(RAM_AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign sin_rdata  = prot_lock ? '0 : ram_rdata;
  assign lreq_ready = l_ram_ok || ob_done;
  assign lreq_rdata = ob_busy ? sout_rdata : ram_rdata;

  assign show_take = l_ram_ok &&
                     ((show_mode == SHOW_ALL) || ((show_mode == SHOW_WR) && lreq_we));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_valid <= 1'b0;
      show_addr  <= '0;
      show_we    <= 1'b0;
      show_data  <= '0;
    end else begin
      show_valid <= show_take;
      if (show_take) begin
        show_addr <= lreq_addr;
        show_we   <= lreq_we;
        show_data <= lreq_we ? lreq_wdata : ram_rdata;
      end
    end
  end
endmodule

// File: rtl/lsb_bridge_chk.sv
module lsb_bridge_chk #(
  parameter int AW   = 16,
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lreq_valid,
  input logic            lreq_ready,
  input logic            sin_valid,
  input logic            sin_ready,
  input logic            sin_retry,
  input logic            sin_err,
  input logic            sout_valid,
  input logic            sout_ready,
  input logic [AW-1:0]   sout_addr,
  input logic [NSEL-1:0] mod_sel,
  input logic            show_valid,
  input logic            prot_set,
  input logic            prot_lock
);
  p_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sin_valid && sin_ready && !sout_valid |-> !lreq_ready);

  p_fwd_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_ready && sout_valid |-> sout_ready);

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid && sout_ready |=> !sout_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid && !sout_ready |=> sout_valid && $stable(sout_addr));

  p_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sin_valid && sin_ready |=> (sin_valid == sin_retry) && !sin_ready);

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_sel));

  p_sel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lreq_valid |-> (mod_sel == '0));

  p_sel_noack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sel != '0) |-> !lreq_ready);

  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_set |=> prot_lock);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_lock |=> prot_lock);

  p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sin_err |-> sin_ready && prot_lock);

  p_show_r8: assert property (@(posedge clk) disable iff (!rst_n)
    show_valid |-> $past(lreq_valid && lreq_ready && !sout_valid));
endmodule

bind lsb_bridge lsb_bridge_chk #(.AW(AW), .NSEL(NSEL)) i_chk (
  .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_ready(lreq_ready),
  .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_retry(sin_retry),
  .sin_err(sin_err), .sout_valid(sout_valid), .sout_ready(sout_ready),
  .sout_addr(sout_addr), .mod_sel(mod_sel), .show_valid(show_valid),
  .prot_set(prot_set), .prot_lock(prot_lock)
);

// File: tb/test_lsb_bridge.sv
`timescale 1ns/1ps
module test_lsb_bridge;
  localparam int AW = 16, DW = 32, RAM_AW = 6, NSEL = 4, SEL_AW = 4;
  localparam int RAM_WORDS = 1 << RAM_AW;
  localparam int SPAN = 1 << SEL_AW;
  localparam logic [AW-1:0] WBASE = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              lreq_valid = 0, lreq_we = 0, lreq_ready;
  logic [AW-1:0]     lreq_addr = '0;
  logic [DW-1:0]     lreq_wdata = '0, lreq_rdata;
  logic              sin_valid = 0, sin_we = 0, sin_ready, sin_retry, sin_err;
  logic [RAM_AW-1:0] sin_addr = '0;
  logic [DW-1:0]     sin_wdata = '0, sin_rdata;
  logic              sout_valid, sout_ready, sout_we;
  logic [AW-1:0]     sout_addr;
  logic [DW-1:0]     sout_wdata, sout_rdata;
  logic [AW-1:0]     win_base = WBASE;
  logic [NSEL-1:0]   mod_sel;
  logic [1:0]        show_mode = 2'd0;
  logic              show_valid, show_we;
  logic [AW-1:0]     show_addr;
  logic [DW-1:0]     show_data;
  logic              prot_set = 0, prot_lock;
  logic              slv_go = 1'b1;

  assign sout_ready = sout_valid && slv_go;
  assign sout_rdata = {16'hA5C3, sout_addr};

  lsb_bridge #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW), .NSEL(NSEL), .SEL_AW(SEL_AW)) i_lsb_bridge (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_addr(lreq_addr),
    .lreq_we(lreq_we), .lreq_wdata(lreq_wdata), .lreq_rdata(lreq_rdata),
    .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_retry(sin_retry),
    .sin_err(sin_err), .sin_addr(sin_addr), .sin_we(sin_we),
    .sin_wdata(sin_wdata), .sin_rdata(sin_rdata),
    .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_addr(sout_addr),
    .sout_we(sout_we), .sout_wdata(sout_wdata), .sout_rdata(sout_rdata),
    .win_base(win_base), .mod_sel(mod_sel), .show_mode(show_mode),
    .show_valid(show_valid), .show_addr(show_addr), .show_we(show_we),
    .show_data(show_data), .prot_set(prot_set), .prot_lock(prot_lock)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int            m_phase = 0;          // 0 idle, 1 outbound waiting, 2 gap
  logic [AW-1:0] m_oaddr = '0;
  logic          m_owe = 0;
  logic [DW-1:0] m_owdata = '0;
  bit            m_prev = 0, m_lock = 0;
  logic [DW-1:0] m_mem [RAM_WORDS];
  bit            m_sv = 0, m_swe = 0;
  logic [AW-1:0] m_sa = '0;
  logic [DW-1:0] m_sd = '0;

  initial for (int i = 0; i < RAM_WORDS; i++) m_mem[i] = '0;

  always @(negedge clk) begin : model
    bit in_go, hit, inw, lok, launch, done, nsv;
    logic [AW-1:0] offv;
    logic [NSEL-1:0] esel;
    logic [DW-1:0] nsd;
    if (!rst_n) begin
      m_phase = 0; m_prev = 0; m_lock = 0; m_sv = 0;
      for (int i = 0; i < RAM_WORDS; i++) m_mem[i] = '0;
    end else begin
      in_go  = sin_valid && !m_prev;
      hit    = (int'(lreq_addr) < RAM_WORDS);
      offv   = lreq_addr - win_base;
      inw    = !hit && (int'(offv) < NSEL * SPAN);
      esel   = (lreq_valid && inw) ? (NSEL'(1) << (offv / SPAN)) : '0;
      lok    = lreq_valid && hit && !in_go && (m_phase != 1);
      launch = lreq_valid && !hit && !inw && !in_go && (m_phase != 1);
      done   = (m_phase == 1) && sout_ready;

      chk("R1 lreq_ready", lreq_ready, lok || done);
      if (lok)  chk("R9 lreq_rdata ram", lreq_rdata, m_mem[lreq_addr[RAM_AW-1:0]]);
      if (done) chk("R2 lreq_rdata forwarded", lreq_rdata, sout_rdata);
      chk("R4 sin_ready", sin_ready, in_go);
      chk("R4 sin_retry", sin_retry, sin_valid && m_prev);
      chk("R7 sin_err", sin_err, in_go && m_lock);
      if (in_go && !sin_we) chk("R7 sin_rdata", sin_rdata, m_lock ? '0 : m_mem[sin_addr]);
      chk("R3 sout_valid", sout_valid, m_phase == 1);
      if (m_phase == 1) begin
        chk("R2 sout_addr", sout_addr, m_oaddr);
        chk("R2 sout_we", sout_we, m_owe);
        chk("R2 sout_wdata", sout_wdata, m_owdata);
      end
      chk("R5 mod_sel", mod_sel, esel);
      chk("R8 show_valid", show_valid, m_sv);
      if (m_sv) begin
        chk("R8 show_addr", show_addr, m_sa);
        chk("R8 show_we", show_we, m_swe);
        chk("R8 show_data", show_data, m_sd);
      end
      chk("R6 prot_lock", prot_lock, m_lock);

      nsv = lok && ((show_mode == 2'd1) || ((show_mode == 2'd2) && lreq_we));
      nsd = lreq_we ? lreq_wdata : m_mem[lreq_addr[RAM_AW-1:0]];
      if (nsv) begin m_sa = lreq_addr; m_swe = lreq_we; m_sd = nsd; end
      m_sv = nsv;
      if (m_phase == 1) m_phase = sout_ready ? 2 : 1;
      else if (launch) begin
        m_phase = 1; m_oaddr = lreq_addr; m_owe = lreq_we; m_owdata = lreq_wdata;
      end else m_phase = 0;
      if (in_go && !m_lock && sin_we) m_mem[sin_addr] = sin_wdata;
      if (lok && lreq_we) m_mem[lreq_addr[RAM_AW-1:0]] = lreq_wdata;
      m_prev = in_go;
      m_lock = m_lock || prot_set;
    end
  end

  // all tasks start and end just after a rising edge
  task automatic l_go(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    bit got;
    lreq_valid = 1; lreq_addr = a; lreq_we = w; lreq_wdata = d;
    do begin
      @(negedge clk); got = lreq_ready;
      @(posedge clk); #1;
    end while (!got);
    lreq_valid = 0;
  endtask

  task automatic s_go(input logic [RAM_AW-1:0] a, input logic w, input logic [DW-1:0] d);
    bit got;
    sin_valid = 1; sin_addr = a; sin_we = w; sin_wdata = d;
    do begin
      @(negedge clk); got = sin_ready;
      @(posedge clk); #1;
    end while (!got);
    sin_valid = 0;
  endtask

  task automatic l_peek(input logic [AW-1:0] a);
    lreq_valid = 1; lreq_addr = a; lreq_we = 0;
    @(posedge clk); #1;
    lreq_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 reset lreq_ready", lreq_ready, 0);
    chk("R10 reset sin_ready", sin_ready, 0);
    chk("R10 reset sout_valid", sout_valid, 0);
    chk("R10 reset show_valid", show_valid, 0);
    chk("R10 reset prot_lock", prot_lock, 0);
    chk("R10 reset mod_sel", mod_sel, 0);
    @(posedge clk); #1;
    l_go(16'd9, 0, '0);                       // R10 RAM reads zero after reset

    // R9 local RAM writes and read-back, including the top word
    for (int i = 0; i < 8; i++) l_go(AW'(i), 1, 32'h1000_0000 + i);
    for (int i = 0; i < 8; i++) l_go(AW'(i), 0, '0);
    l_go(AW'(RAM_WORDS - 1), 1, 32'h7777_0001);
    l_go(AW'(RAM_WORDS - 1), 0, '0);

    // R1 inbound and local RAM start together
    fork
      s_go(6'd5, 1, 32'hBEEF_0005);
      l_go(16'd6, 1, 32'hCAFE_0006);
    join
    idle(1);
    fork
      s_go(6'd6, 0, '0);
      l_go(16'd5, 0, '0);
    join

    // R4 back-to-back inbound accesses
    s_go(6'd10, 1, 32'h0000_AAAA);
    s_go(6'd11, 1, 32'h0000_BBBB);
    s_go(6'd10, 0, '0);
    s_go(6'd11, 0, '0);

    // R2/R3 forwarding, back-to-back and with a stalling slave
    l_go(16'h0400, 1, 32'h4444_0400);
    l_go(16'h0401, 0, '0);
    l_go(16'h8000, 0, '0);
    fork
      l_go(16'h0500, 1, 32'h5555_0500);
      begin slv_go = 0; idle(4); slv_go = 1; end
    join
    fork
      l_go(16'h0600, 0, '0);
      s_go(6'd12, 1, 32'h0000_CCCC);
    join

    // R5 window selects, edges and precedence of the RAM
    for (int k = 0; k < NSEL; k++) l_peek(WBASE + AW'(k * SPAN + 3));
    l_peek(WBASE + AW'(NSEL * SPAN - 1));
    l_go(WBASE - 1, 0, '0);
    l_go(WBASE + AW'(NSEL * SPAN), 0, '0);
    win_base = 16'h0020;
    l_go(16'h0030, 1, 32'h3030_3030);
    l_peek(16'h0040);
    win_base = WBASE;

    // R8 each show code
    for (int m = 0; m < 4; m++) begin
      show_mode = 2'(m);
      l_go(16'd2, 1, 32'h5A00_0000 + m);
      l_go(16'd2, 0, '0);
      idle(1);
    end

    // R6/R7 protection lock
    s_go(6'd20, 1, 32'h2020_2020);
    idle(1);
    prot_set = 1; idle(1); prot_set = 0;
    s_go(6'd20, 1, 32'hDEAD_DEAD);
    idle(1);
    s_go(6'd20, 0, '0);
    l_go(16'd20, 0, '0);
    idle(5);

    // mixed random traffic with a randomly stalling slave
    show_mode = 2'd1;
    fork
      begin
        for (int it = 0; it < 300; it++) begin
          int r;
          r = $urandom_range(0, 9);
          if (r < 4)      l_go(AW'($urandom_range(0, RAM_WORDS - 1)), 1'($urandom_range(0, 1)), $urandom);
          else if (r < 8) l_go(16'h0800 + AW'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), $urandom);
          else            l_peek(WBASE + AW'($urandom_range(0, NSEL * SPAN - 1)));
        end
      end
      begin
        for (int it = 0; it < 300; it++) begin
          s_go(6'($urandom_range(0, RAM_WORDS - 1)), 1'($urandom_range(0, 1)), $urandom);
          idle($urandom_range(0, 2));
        end
      end
      begin
        for (int it = 0; it < 1500; it++) begin
          slv_go = 1'($urandom_range(0, 2) != 0);
          idle(1);
        end
        slv_go = 1;
      end
    join
    idle(4);
    finish_run();
  end
endmodule